// File: doc/BRIEF.md
# Serial Receiver with Interrupt Flags

This block receives asynchronous serial frames in one of two frame sizes and keeps the flags a processor core polls or takes interrupts on. One frame size carries eight data bits and the other nine, each framed by a start bit and a stop bit. The line is oversampled at sixteen times the bit rate, and a majority vote decides each bit. A start bit that does not hold low at mid-bit is treated as noise. An optional framing check can be switched on. It moves the point at which "frame received" is raised from the ninth data bit to the stop bit, and it reports a low stop bit on a flag of its own.

Software controls the block through an 8-bit control register and an 8-bit enable register, both written over a simple write port. The receive flag and the transmit flag are raised by hardware and are only ever cleared by a software write. The transmitter is not part of this block and shows up only as a one-cycle "transmit done" pulse. The two flags are ORed into one interrupt request, which also needs a local enable and a global enable. The received word is presented on a 9-bit buffer output.

Top module: `sio_rx_irq`

## Requirements
- R1: After a synchronous reset, the control register, the enable register and the receive buffer read zero, and `irq` is low.
- R2: The receive flag (control bit 0) and the transmit flag (control bit 1) are set by hardware and cleared only when software writes the control register with a 0 in that bit. A hardware set in the same cycle as a clearing write wins. A `tx_done` pulse sets the transmit flag on the next clock edge.
- R3: `irq` is high exactly when (receive flag OR transmit flag) is set AND enable bit 4 (local serial enable) is set AND enable bit 7 (global enable) is set.
- R4: The line is resynchronised through two flip-flops. The first `smp_tick` that sees it low is sample 0 of the start bit. Each bit spans 16 ticks, and its value is the majority of its samples 7, 8 and 9. So a single wrong sample among them has no effect, and two wrong ones flip the bit.
- R5: With the mode field (control bits 3:2) at 01, the frame has 8 data bits, LSB first. The receive flag rises on the edge of the tick at sample 9 of the stop bit (tick 153 counted from sample 0).
- R6: With the mode field at 10 or 11 and framing check off (control bit 5 = 0), the frame has 9 data bits. The receive flag rises at sample 9 of the ninth data bit (tick 153), and the framing-error flag is never set.
- R7: With framing check on (control bit 5 = 1), the receive flag rises at sample 9 of the stop bit: tick 153 for 8-bit frames and tick 169 for 9-bit frames. The framing-error flag (control bit 6) is set on that same edge if the stop bit reads low.
- R8: The framing-error flag is sticky. A later good frame leaves it set, and only a software write of 0 clears it.
- R9: The receive buffer `rx_data` loads on the same edge that raises the receive flag and holds otherwise. Bits 7:0 carry D7..D0. Bit 8 carries D8 in 9-bit frames and the stop-bit value in 8-bit frames.
- R10: If the start bit reads high by majority at mid-bit, the reception is abandoned. No flag is raised and the buffer is unchanged.
- R11: The receiver runs only when the receive-enable bit (control bit 4) is set and the mode field is not 00. Otherwise frames on the line leave the flags and the buffer unchanged.
- R12: Control register layout: bit 0 receive flag, bit 1 transmit flag, bits 3:2 mode, bit 4 receive enable, bit 5 framing check select, bit 6 framing error, bit 7 reads 0. The enable register keeps only bits 4 and 7; its other bits read 0. `wr_sel` = 0 addresses the control register and 1 the enable register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects control register, 1 selects enable register |
| wr_data | input | 8 | Write data |
| tx_done | input | 1 | One-cycle pulse from the transmitter when a frame has gone out |
| ctrl_q | output | 8 | Control register contents |
| ien_q | output | 8 | Enable register contents |
| rx_data | output | 9 | Receive buffer |
| irq | output | 1 | Combined serial interrupt request |

## Verification
The hardest cases to reach from the ports are the majority vote and the exact edge on which the receive flag rises, since both depend on where individual oversampled points fall. The bench drives the line one tick at a time and can invert one or two chosen samples of a chosen bit. It also tracks the tick index inside its own reference, so the receive flag is compared on every clock, including the edge one cycle before it is due. The framing-error and glitched-start paths are reached by driving a low stop bit, or a start bit that returns high before sample 7.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int SIO_DW   = 8;
    localparam int BUF_W    = SIO_DW + 1;
    localparam int REG_W    = 8;
    localparam int EN_LOCAL = 4;
    localparam int EN_GLOBAL = 7;
    localparam logic [REG_W-1:0] IEN_MASK = REG_W'((1 << EN_LOCAL) | (1 << EN_GLOBAL));

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    typedef enum logic [1:0] {
        MODE_OFF = 2'b00,
        MODE_8B  = 2'b01,
        MODE_9A  = 2'b10,
        MODE_9B  = 2'b11
    } sio_mode_e;

    typedef struct packed {
        logic       rsvd;
        logic       fe_flag;
        logic       fe_sel;
        logic       ren;
        logic [1:0] mode;
        logic       tx_flag;
        logic       rx_flag;
    } ctrl_t;

    typedef struct packed {
        logic             valid;
        logic             fe;
        logic [BUF_W-1:0] data;
    } rx_evt_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sio_rx_engine.sv
module sio_rx_engine
    import sio_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    rx,
    input  logic    active,
    input  logic    nine,
    input  logic    fe_sel,
    output rx_evt_t evt
);
    localparam int CW  = $clog2(OVS);
    localparam int MID = OVS / 2;
    localparam int SA  = MID - 1;
    localparam int SB  = MID;
    localparam int SC  = MID + 1;
    localparam int BW  = $clog2(BUF_W + 1);

    rx_state_e        state;
    logic [CW-1:0]    cnt;
    logic [BW-1:0]    bitn;
    logic [BUF_W-1:0] shreg;
    logic             va, vb;

    logic          decide, last_smp, bit_v;
    logic [BW-1:0] last_bit;

    always_comb begin
        decide   = tick && (cnt == CW'(SC));
        last_smp = tick && (cnt == CW'(OVS - 1));
        bit_v    = maj3(va, vb, rx);
        last_bit = nine ? BW'(SIO_DW) : BW'(SIO_DW - 1);
    end

    // frame-complete event: raised on the deciding sample
    always_comb begin
        evt = '0;
        unique case (state)
            RX_DATA: begin
                if (decide && nine && !fe_sel && bitn == BW'(SIO_DW)) begin
                    evt.valid = 1'b1;
                    evt.data  = {bit_v, shreg[SIO_DW-1:0]};
                end
            end
            RX_STOP: begin
                if (decide && (!nine || fe_sel)) begin
                    evt.valid = 1'b1;
                    evt.fe    = fe_sel & ~bit_v;
                    evt.data  = nine ? shreg : {bit_v, shreg[SIO_DW-1:0]};
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RX_IDLE;
            cnt   <= '0;
            bitn  <= '0;
            shreg <= '0;
            va    <= 1'b1;
            vb    <= 1'b1;
        end else if (!active) begin
            state <= RX_IDLE;
            cnt   <= '0;
        end else if (tick) begin
            if (cnt == CW'(SA)) va <= rx;
            if (cnt == CW'(SB)) vb <= rx;
            cnt <= last_smp ? '0 : cnt + 1'b1;
            unique case (state)
                RX_IDLE: begin
                    if (!rx) begin
                        state <= RX_START;
                        cnt   <= CW'(1);
                    end else begin
                        cnt <= '0;
                    end
                end
                RX_START: begin
                    if (decide && bit_v) begin
                        state <= RX_IDLE;
                        cnt   <= '0;
                    end else if (last_smp) begin
                        state <= RX_DATA;
                        bitn  <= '0;
                    end
                end
                RX_DATA: begin
                    if (decide) shreg[bitn] <= bit_v;
                    if (last_smp) begin
                        if (bitn == last_bit) state <= RX_STOP;
                        else                  bitn  <= bitn + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (decide) begin
                        state <= RX_IDLE;
                        cnt   <= '0;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sio_flag_regs.sv
module sio_flag_regs
    import sio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             tx_done,
    input  rx_evt_t          evt,
    output ctrl_t            ctrl,
    output logic [REG_W-1:0] ien,
    output logic [BUF_W-1:0] rbuf,
    output logic             irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            ien  <= '0;
            rbuf <= '0;
        end else begin
            if (wr_en && !wr_sel) ctrl <= ctrl_t'(wr_data);
            if (wr_en &&  wr_sel) ien  <= wr_data & IEN_MASK;
            ctrl.rsvd <= 1'b0;
            if (tx_done) ctrl.tx_flag <= 1'b1;
            if (evt.valid) begin
                ctrl.rx_flag <= 1'b1;
                rbuf         <= evt.data;
                if (evt.fe) ctrl.fe_flag <= 1'b1;
            end
        end
    end

    assign irq = (ctrl.rx_flag | ctrl.tx_flag) & ien[EN_LOCAL] & ien[EN_GLOBAL];
endmodule

// File: rtl/sio_rx_irq.sv
module sio_rx_irq
    import sio_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_tick,
    input  logic             rxd,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             tx_done,
    output logic [REG_W-1:0] ctrl_q,
    output logic [REG_W-1:0] ien_q,
    output logic [BUF_W-1:0] rx_data,
    output logic             irq
);
    logic    rx_s;
    ctrl_t   ctrl;
    rx_evt_t evt;
    logic    rx_done;
    logic    active;

    assign active  = ctrl.ren && (ctrl.mode != MODE_OFF);
    assign rx_done = evt.valid;
    assign ctrl_q  = ctrl;

    sio_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (rxd),
        .q   (rx_s)
    );

    sio_rx_engine #(.OVS(OVS)) u_eng (
        .clk    (clk),
        .rst    (rst),
        .tick   (smp_tick),
        .rx     (rx_s),
        .active (active),
        .nine   (ctrl.mode[1]),
        .fe_sel (ctrl.fe_sel),
        .evt    (evt)
    );

    sio_flag_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .tx_done (tx_done),
        .evt     (evt),
        .ctrl    (ctrl),
        .ien     (ien_q),
        .rbuf    (rx_data),
        .irq     (irq)
    );
endmodule

// File: rtl/sio_rx_irq_chk.sv
module sio_rx_irq_chk
    import sio_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             wr_sel,
    input logic             wr_rx_bit,
    input logic             wr_fe_bit,
    input logic             tx_done,
    input logic [REG_W-1:0] ctrl_q,
    input logic             en_local,
    input logic             en_global,
    input logic [BUF_W-1:0] rx_data,
    input logic             irq,
    input logic             rx_done
);
    assert_reset_clean_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ctrl_q == '0 && !en_local && !en_global && rx_data == '0 && !irq));

    assert_irq_enables_R3: assert property (@(posedge clk) disable iff (rst)
        irq |-> (en_local && en_global));

    assert_irq_flag_R3: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ctrl_q[0] || ctrl_q[1]));

    assert_rx_clear_by_sw_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_q[0]) |-> $past(wr_en && !wr_sel && !wr_rx_bit));

    assert_tx_sets_flag_R2: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> ctrl_q[1]);

    assert_fe_source_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_q[6]) |-> ($past(rx_done && ctrl_q[5]) || $past(wr_en && !wr_sel && wr_fe_bit)));

    assert_buf_only_on_done_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_data) |-> $past(rx_done));

    assert_done_sets_flag_R9: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> ctrl_q[0]);

    assert_rx_needs_enable_R11: assert property (@(posedge clk) disable iff (rst)
        rx_done |-> (ctrl_q[4] && ctrl_q[3:2] != 2'b00));

    assert_rsvd_low_R12: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q[7]);
endmodule

bind sio_rx_irq sio_rx_irq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_rx_bit (wr_data[0]),
    .wr_fe_bit (wr_data[6]),
    .tx_done   (tx_done),
    .ctrl_q    (ctrl_q),
    .en_local  (ien_q[4]),
    .en_global (ien_q[7]),
    .rx_data   (rx_data),
    .irq       (irq),
    .rx_done   (rx_done)
);

// File: tb/sim_sio_rx_irq.sv
module sim_sio_rx_irq;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int OVS        = 16;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       smp_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tx_done = 1'b0;
    logic [7:0] ctrl_q, ien_q;
    logic [8:0] rx_data;
    logic       irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;
    int cyc      = 0;

    sio_rx_irq u0 (
        .clk(clk), .rst(rst), .smp_tick(smp_tick), .rxd(rxd),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .tx_done(tx_done),
        .ctrl_q(ctrl_q), .ien_q(ien_q), .rx_data(rx_data), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int phase = 0;
    always @(negedge clk) begin
        smp_tick = (phase == TICK_DIV - 1);
        phase    = (phase + 1) % TICK_DIV;
    end

    // ---------------- reference model ----------------
    logic [7:0] m_ctrl = 8'h00;
    logic [7:0] m_ien  = 8'h00;
    logic [8:0] m_data = 9'h000;
    int  arm_req = 0, arm_seen = 0, idx = 0;
    bit  act = 0;
    int  f_ri_at = -1, f_end = 0;
    bit  f_fe = 0;
    logic [8:0] f_data = 9'h000;

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl = 8'h00; m_ien = 8'h00; m_data = 9'h000;
            act = 0; arm_seen = arm_req;
        end else begin
            if (wr_en) begin
                if (!wr_sel) m_ctrl = wr_data & 8'h7F;
                else         m_ien  = wr_data & 8'h90;
            end
            if (tx_done) m_ctrl[1] = 1'b1;
            if (smp_tick) begin
                if (arm_req != arm_seen) begin
                    arm_seen = arm_req; act = 1; idx = 0;
                end else if (act) begin
                    idx++;
                end
                if (act && idx == f_ri_at) begin
                    m_ctrl[0] = 1'b1;
                    m_data    = f_data;
                    if (f_fe) m_ctrl[6] = 1'b1;
                end
                if (act && idx >= f_end) act = 0;
            end
        end
    end

    task automatic check(input int actual, input int expected, input string tag);
        n_checks++;
        if (actual !== expected) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, actual, expected, cyc);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(int'(ctrl_q[0]), int'(m_ctrl[0]), "R5 rx flag");
            check(int'(ctrl_q[1]), int'(m_ctrl[1]), "R2 tx flag");
            check(int'(ctrl_q[6]), int'(m_ctrl[6]), "R8 fe flag");
            check(int'(ctrl_q), int'(m_ctrl), "R12 control reg");
            check(int'(ien_q), int'(m_ien), "R12 enable reg");
            check(int'(rx_data), int'(m_data), "R9 rx buffer");
            check(int'(irq), int'((m_ctrl[0] | m_ctrl[1]) & m_ien[4] & m_ien[7]), "R3 irq");
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !finished) begin
            finished = 1;
            n_fails++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic write_reg(input logic sel, input logic [7:0] d, input logic with_tx);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d; tx_done = with_tx;
        @(negedge clk);
        wr_en = 1'b0; tx_done = 1'b0;
    endtask

    task automatic next_sample();
        @(posedge clk iff smp_tick);
        @(negedge clk);
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) @(posedge clk iff smp_tick);
        @(negedge clk);
    endtask

    // nd data bits, glitch inverts samples gs..gs+gn-1 of bit gb
    task automatic send_frame(input int nd, input logic [8:0] d, input logic stopv,
                              input int gb, input int gs, input int gn,
                              input int ri_at, input bit fe, input logic [8:0] expd);
        int total;
        total   = (nd + 2) * OVS;
        f_ri_at = ri_at; f_fe = fe; f_data = expd; f_end = total - 1;
        next_sample();
        for (int s = 0; s < total; s++) begin
            int b, k;
            logic v;
            if (s > 0) next_sample();
            b = s / OVS; k = s % OVS;
            if (b == 0)            v = 1'b0;
            else if (b <= nd)      v = d[b-1];
            else                   v = (k <= 9) ? stopv : 1'b1;
            if (b == gb && k >= gs && k < gs + gn) v = ~v;
            rxd = v;
            if (s == 0) arm_req++;
        end
        next_sample();
        rxd = 1'b1;
        wait_ticks(6);
    endtask

    task automatic glitch_start();
        f_ri_at = -1; f_fe = 0; f_end = 20;
        next_sample();
        rxd = 1'b0; arm_req++;
        for (int s = 1; s < 6; s++) next_sample();
        next_sample();
        rxd = 1'b1;
        wait_ticks(40);
    endtask

    // ---------------- test sequence ----------------
    initial begin
        repeat (4) @(negedge clk);
        check(int'(ctrl_q), 0, "R1 reset ctrl");
        check(int'(ien_q), 0, "R1 reset enable");
        check(int'(rx_data), 0, "R1 reset buffer");
        check(int'(irq), 0, "R1 reset irq");
        rst = 1'b0;
        wait_ticks(2);

        // mode 01, 8-bit frame
        write_reg(1'b0, 8'h14, 1'b0);
        send_frame(8, 9'h0A5, 1'b1, -1, 0, 0, 153, 0, 9'h1A5);
        check(int'(ctrl_q[0]), 1, "R5 flag after 8-bit frame");
        check(int'(rx_data), 9'h1A5, "R5 buffer after 8-bit frame");
        check(int'(irq), 0, "R3 no irq with enables off");
        write_reg(1'b1, 8'h10, 1'b0);
        check(int'(irq), 0, "R3 no irq without global enable");
        write_reg(1'b1, 8'hFF, 1'b0);
        check(int'(ien_q), 8'h90, "R12 enable reg keeps bits 4 and 7");
        check(int'(irq), 1, "R3 irq with both enables");
        write_reg(1'b0, 8'h14, 1'b0);
        check(int'(ctrl_q[0]), 0, "R2 software clear of rx flag");

        // mode 10, no framing check: flag at D8
        write_reg(1'b0, 8'h18, 1'b0);
        send_frame(9, 9'h13C, 1'b0, -1, 0, 0, 153, 0, 9'h13C);
        check(int'(rx_data), 9'h13C, "R6 nine-bit data");
        check(int'(ctrl_q[6]), 0, "R6 no framing error when check off");

        // mode 11, framing check on, bad stop
        write_reg(1'b0, 8'h3C, 1'b0);
        send_frame(9, 9'h0C3, 1'b0, -1, 0, 0, 169, 1, 9'h0C3);
        check(int'(ctrl_q[6]), 1, "R7 framing error on low stop");
        check(int'(ctrl_q[0]), 1, "R7 flag at stop bit");

        // sticky framing error across a good frame
        write_reg(1'b0, 8'h7C, 1'b0);
        send_frame(9, 9'h155, 1'b1, -1, 0, 0, 169, 0, 9'h155);
        check(int'(ctrl_q[6]), 1, "R8 framing error stays set");
        write_reg(1'b0, 8'h3C, 1'b0);
        check(int'(ctrl_q[6]), 0, "R8 framing error cleared by write");

        // 8-bit frame with framing check, bad stop
        write_reg(1'b0, 8'h34, 1'b0);
        send_frame(8, 9'h05A, 1'b0, -1, 0, 0, 153, 1, 9'h05A);
        check(int'(rx_data), 9'h05A, "R9 stop value in bit 8");
        check(int'(ctrl_q[6]), 1, "R7 framing error 8-bit");

        // majority vote
        write_reg(1'b0, 8'h14, 1'b0);
        send_frame(8, 9'h00F, 1'b1, 4, 8, 1, 153, 0, 9'h10F);
        check(int'(rx_data), 9'h10F, "R4 single bad sample ignored");
        write_reg(1'b0, 8'h14, 1'b0);
        send_frame(8, 9'h00F, 1'b1, 6, 7, 2, 153, 0, 9'h12F);
        check(int'(rx_data), 9'h12F, "R4 two bad samples flip bit");

        // glitched start
        write_reg(1'b0, 8'h14, 1'b0);
        glitch_start();
        check(int'(ctrl_q[0]), 0, "R10 glitch raises no flag");
        check(int'(rx_data), 9'h12F, "R10 glitch leaves buffer");

        // receiver disabled
        write_reg(1'b0, 8'h04, 1'b0);
        send_frame(8, 9'h0E7, 1'b1, -1, 0, 0, -1, 0, 9'h000);
        check(int'(ctrl_q[0]), 0, "R11 disabled receiver ignores frame");
        write_reg(1'b0, 8'h10, 1'b0);
        send_frame(8, 9'h0E7, 1'b1, -1, 0, 0, -1, 0, 9'h000);
        check(int'(rx_data), 9'h12F, "R11 mode 00 ignores frame");

        // transmit flag
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
        check(int'(ctrl_q[1]), 1, "R2 tx_done sets flag");
        check(int'(irq), 1, "R3 irq from tx flag");
        write_reg(1'b0, 8'h10, 1'b1);
        check(int'(ctrl_q[1]), 1, "R2 hardware set wins over clear");
        write_reg(1'b0, 8'h10, 1'b0);
        check(int'(ctrl_q[1]), 0, "R2 tx flag cleared");
        check(int'(irq), 0, "R3 irq drops with flags");

        repeat (4) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule